// File: doc/BRIEF.md
# I2C Master Transfer Sequencer

This block turns one write of a control byte into a complete I2C master command at byte level. When the control byte arrives with its go bit set, the sequencer takes the target address and direction, then moves between one and four bytes. On a write, the bytes come from a four-entry data buffer. On a read, they are stored into that buffer. Between bytes it either releases the bus with a stop or holds it, according to the chain and repeated-start bits. A halt request in the same byte closes a bus that was left open.

Bit timing on the wire belongs to a separate bit-level engine. The sequencer drives that engine through a request/done handshake. Each request names one of four operations: address start, send byte, receive byte or stop. The engine reports its bus-busy state and, with each done pulse, whether the target acknowledged. After each command the sequencer leaves an error flag, a sticky abort flag, a transfer count and a buffer occupancy. It pulses one event line when a transfer completes and another when a halt completes.

Top module: `i2cseq_top`

## Requirements
- R1: Control byte layout, with bit 0 as the least significant: bit 0 go, bit 1 read (1) or write (0), bit 2 chain, bit 3 repeated start, bits 5:4 byte count minus one, bit 6 ten-bit address request, bit 7 halt. A byte with go clear and no effective halt starts nothing.
- R2: The start operation carries the address `addr_lo[7:1]` and the direction from bit 1. A ten-bit request (bit 6) is accepted, but the command still runs with the same 7-bit address.
- R3: Before each byte, a start operation is issued only if `bus_busy` is low. A byte that finds the bus held goes out with no new start.
- R4: A nack on a start operation sets `err` and `abort_flag` and ends the command, and the byte in progress does not count.
- R5: On a write, byte i is sent from buffer entry i. A nack on a sent byte sets `err` and `abort_flag` and ends the command without a stop.
- R6: On a read, received byte i is stored in buffer entry i, which can be read back through `buf_rd_idx`/`buf_rd_data`.
- R7: After each completed byte, a stop is issued when repeated start is set or chain is clear. Otherwise the bus stays held.
- R8: At completion, `xfer_cnt` and `occupancy` both equal the number of bytes completed. `xfer_done` pulses once only when that number is at least one.
- R9: A start operation that is acknowledged clears `err`. `abort_flag` stays set until reset.
- R10: A control byte with halt set while `bus_busy` is high issues only a stop and pulses `halt_done` once. No transfer runs, even if go is also set.
- R11: `busy` rises on the clock after an accepted control byte and falls after completion. Control bytes that arrive while `busy` is high are ignored. After reset `busy`, `err`, `abort_flag`, `xfer_cnt` and `occupancy` are zero.
- R12: Engine handshake: `eng_req` stays high with a stable `eng_op` until `eng_done`. Operation codes are 0 start, 1 send, 2 receive, 3 stop.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctrl_wr | input | 1 | Control byte strobe |
| ctrl_byte | input | 8 | Control byte |
| addr_lo | input | 8 | Low master address; bits 7:1 are the target |
| buf_wr | input | 1 | Host write into the data buffer |
| buf_wr_idx | input | 2 | Buffer entry to write |
| buf_wr_data | input | 8 | Data to write |
| buf_rd_idx | input | 2 | Buffer entry to read |
| buf_rd_data | output | 8 | Buffer entry contents |
| bus_busy | input | 1 | Bus held, reported by the bit engine |
| eng_req | output | 1 | Operation request to the bit engine |
| eng_op | output | 2 | Operation code |
| eng_addr | output | 7 | Target address for start |
| eng_rd | output | 1 | Direction for start |
| eng_wdata | output | 8 | Byte to send |
| eng_done | input | 1 | Operation finished (one cycle) |
| eng_nack | input | 1 | No acknowledge, valid with eng_done |
| eng_rdata | input | 8 | Received byte, valid with eng_done |
| busy | output | 1 | Command in progress |
| err | output | 1 | Error status |
| abort_flag | output | 1 | Sticky abort indication |
| xfer_cnt | output | 3 | Bytes completed by last command |
| occupancy | output | 3 | Buffer occupancy after last command |
| xfer_done | output | 1 | Transfer-complete event |
| halt_done | output | 1 | Halt-complete event |

## Verification
`busy` is due one edge after the strobe. It drops one edge after the finishing state, and `xfer_cnt`, `occupancy`, `err` and the buffer are settled by that time. So the bench waits on falling edges for `busy` to go low and waits one more cycle before it compares status, buffer and engine operation counts. The engine model answers on a fixed offset after the rising edge and holds `eng_done` for exactly one cycle. The event lines are counted on falling edges, where `halt_done` and `xfer_done` are each stable for their single cycle. The ignored-write and no-transfer cases are checked a few cycles later by confirming that `busy` is still low and that the engine saw no extra start.

// File: rtl/i2cseq_pkg.sv
`timescale 1ns/1ps
package i2cseq_pkg;

  // Operation codes on the engine handshake
  typedef enum logic [1:0] {
    ENG_START = 2'd0,
    ENG_SEND  = 2'd1,
    ENG_RECV  = 2'd2,
    ENG_STOP  = 2'd3
  } eng_op_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_HALT,
    ST_CHECK,
    ST_ADDR,
    ST_BYTE,
    ST_STOP,
    ST_FINISH
  } seq_state_e;

  // Control byte, most significant field first
  typedef struct packed {
    logic       halt;
    logic       ten_bit;
    logic [1:0] count_m1;
    logic       rpt_start;
    logic       chain;
    logic       rd;
    logic       go;
  } ctrl_fields_t;

endpackage

// File: rtl/i2cseq_ctrl_decode.sv
`timescale 1ns/1ps
module i2cseq_ctrl_decode
  import i2cseq_pkg::*;
#(
  parameter int IDX_W = 3
) (
  input  logic [7:0]       ctrl_byte,
  output logic             go,
  output logic             rd,
  output logic             chain,
  output logic             rpt_start,
  output logic             halt,
  output logic [IDX_W-1:0] total
);
  ctrl_fields_t fields;
  logic         unused_ten_bit;

  assign fields    = ctrl_fields_t'(ctrl_byte);
  assign go        = fields.go;
  assign rd        = fields.rd;
  assign chain     = fields.chain;
  assign rpt_start = fields.rpt_start;
  assign halt      = fields.halt;
  // the ten-bit request is accepted but runs as a 7-bit address
  assign unused_ten_bit = fields.ten_bit;
  assign total     = IDX_W'(fields.count_m1) + IDX_W'(1);
endmodule

// File: rtl/i2cseq_buffer.sv
`timescale 1ns/1ps
module i2cseq_buffer #(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 4,
  parameter int PTR_W  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_we,
  input  logic [PTR_W-1:0]  host_idx,
  input  logic [DATA_W-1:0] host_data,
  input  logic              seq_we,
  input  logic [PTR_W-1:0]  seq_idx,
  input  logic [DATA_W-1:0] seq_data,
  input  logic [PTR_W-1:0]  host_rd_idx,
  output logic [DATA_W-1:0] host_rd_data,
  input  logic [PTR_W-1:0]  seq_rd_idx,
  output logic [DATA_W-1:0] seq_rd_data
);
  logic [DATA_W-1:0] ent [DEPTH];

  for (genvar e = 0; e < DEPTH; e++) begin : g_entry
    logic [DATA_W-1:0] q;
    logic              seq_hit;
    logic              host_hit;

    assign seq_hit  = seq_we  && (seq_idx  == PTR_W'(e));
    assign host_hit = host_we && (host_idx == PTR_W'(e));

    // received data wins over a host write to the same entry
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        q <= '0;
      end else if (seq_hit) begin
        q <= seq_data;
      end else if (host_hit) begin
        q <= host_data;
      end
    end
    assign ent[e] = q;
  end

  assign host_rd_data = ent[host_rd_idx];
  assign seq_rd_data  = ent[seq_rd_idx];
endmodule

// File: rtl/i2cseq_fsm.sv
`timescale 1ns/1ps
module i2cseq_fsm
  import i2cseq_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int PTR_W  = 2,
  parameter int IDX_W  = 3,
  parameter int ADDR_W = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_wr,
  input  logic              cmd_go,
  input  logic              cmd_rd,
  input  logic              cmd_chain,
  input  logic              cmd_rpt,
  input  logic              cmd_halt,
  input  logic [IDX_W-1:0]  cmd_total,
  input  logic [ADDR_W-1:0] target,
  input  logic              bus_busy,
  input  logic              eng_done,
  input  logic              eng_nack,
  input  logic [DATA_W-1:0] eng_rdata,
  input  logic [DATA_W-1:0] buf_rdata,
  output logic              eng_req,
  output logic [1:0]        eng_op,
  output logic [ADDR_W-1:0] eng_addr,
  output logic              eng_rd,
  output logic [DATA_W-1:0] eng_wdata,
  output logic              buf_we,
  output logic [PTR_W-1:0]  buf_idx,
  output logic [DATA_W-1:0] buf_wdata,
  output logic              busy,
  output logic              err,
  output logic              abort_flag,
  output logic [IDX_W-1:0]  xfer_cnt,
  output logic [IDX_W-1:0]  occupancy,
  output logic              xfer_done,
  output logic              halt_done
);
  seq_state_e        state_q, state_d;
  logic [IDX_W-1:0]  idx_q, idx_d;
  logic [IDX_W-1:0]  total_q;
  logic              rd_q, chain_q, rpt_q;
  logic [ADDR_W-1:0] addr_q;
  logic              err_q, err_d;
  logic              abort_q, abort_d;
  logic [IDX_W-1:0]  cnt_q;
  logic              latch_cmd;
  logic              finish;
  logic [IDX_W-1:0]  idx_inc;

  assign idx_inc = idx_q + IDX_W'(1);
  assign finish  = (state_q == ST_FINISH);

  // next-state logic
  always_comb begin
    state_d   = state_q;
    idx_d     = idx_q;
    err_d     = err_q;
    abort_d   = abort_q;
    latch_cmd = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (cmd_wr) begin
          if (cmd_halt && bus_busy) begin
            state_d = ST_HALT;
          end else if (cmd_go) begin
            state_d   = ST_CHECK;
            latch_cmd = 1'b1;
            idx_d     = '0;
          end
        end
      end
      ST_HALT: begin
        if (eng_done) state_d = ST_IDLE;
      end
      ST_CHECK: begin
        state_d = bus_busy ? ST_BYTE : ST_ADDR;
      end
      ST_ADDR: begin
        if (eng_done) begin
          if (eng_nack) begin
            err_d   = 1'b1;
            abort_d = 1'b1;
            state_d = ST_FINISH;
          end else begin
            err_d   = 1'b0;
            state_d = ST_BYTE;
          end
        end
      end
      ST_BYTE: begin
        if (eng_done) begin
          if (eng_nack && !rd_q) begin
            err_d   = 1'b1;
            abort_d = 1'b1;
            state_d = ST_FINISH;
          end else begin
            idx_d = idx_inc;
            if (rpt_q || !chain_q) begin
              state_d = ST_STOP;
            end else if (idx_inc == total_q) begin
              state_d = ST_FINISH;
            end else begin
              state_d = ST_CHECK;
            end
          end
        end
      end
      ST_STOP: begin
        if (eng_done) state_d = (idx_q == total_q) ? ST_FINISH : ST_CHECK;
      end
      ST_FINISH: state_d = ST_IDLE;
      default:   state_d = ST_IDLE;
    endcase
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      idx_q   <= '0;
      err_q   <= 1'b0;
      abort_q <= 1'b0;
    end else begin
      state_q <= state_d;
      idx_q   <= idx_d;
      err_q   <= err_d;
      abort_q <= abort_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      total_q <= '0;
      rd_q    <= 1'b0;
      chain_q <= 1'b0;
      rpt_q   <= 1'b0;
      addr_q  <= '0;
    end else if (latch_cmd) begin
      total_q <= cmd_total;
      rd_q    <= cmd_rd;
      chain_q <= cmd_chain;
      rpt_q   <= cmd_rpt;
      addr_q  <= target;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (finish) begin
      cnt_q <= idx_q;
    end
  end

  // outputs
  always_comb begin
    eng_req = 1'b0;
    eng_op  = ENG_STOP;
    unique case (state_q)
      ST_HALT: begin eng_req = 1'b1; eng_op = ENG_STOP;  end
      ST_ADDR: begin eng_req = 1'b1; eng_op = ENG_START; end
      ST_BYTE: begin eng_req = 1'b1; eng_op = rd_q ? ENG_RECV : ENG_SEND; end
      ST_STOP: begin eng_req = 1'b1; eng_op = ENG_STOP;  end
      default: begin eng_req = 1'b0; eng_op = ENG_STOP;  end
    endcase
  end

  assign eng_addr   = addr_q;
  assign eng_rd     = rd_q;
  assign buf_idx    = idx_q[PTR_W-1:0];
  assign eng_wdata  = buf_rdata;
  assign buf_wdata  = eng_rdata;
  assign buf_we     = (state_q == ST_BYTE) && eng_done && rd_q;
  assign busy       = (state_q != ST_IDLE);
  assign err        = err_q;
  assign abort_flag = abort_q;
  assign xfer_cnt   = cnt_q;
  assign occupancy  = cnt_q;
  assign xfer_done  = finish && (idx_q != '0);
  assign halt_done  = (state_q == ST_HALT) && eng_done;
endmodule

// File: rtl/i2cseq_top.sv
`timescale 1ns/1ps
module i2cseq_top #(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 4,
  parameter int ADDR_W = 7,
  localparam int PTR_W = $clog2(DEPTH),
  localparam int IDX_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ctrl_wr,
  input  logic [7:0]        ctrl_byte,
  input  logic [ADDR_W:0]   addr_lo,
  input  logic              buf_wr,
  input  logic [PTR_W-1:0]  buf_wr_idx,
  input  logic [DATA_W-1:0] buf_wr_data,
  input  logic [PTR_W-1:0]  buf_rd_idx,
  output logic [DATA_W-1:0] buf_rd_data,
  input  logic              bus_busy,
  output logic              eng_req,
  output logic [1:0]        eng_op,
  output logic [ADDR_W-1:0] eng_addr,
  output logic              eng_rd,
  output logic [DATA_W-1:0] eng_wdata,
  input  logic              eng_done,
  input  logic              eng_nack,
  input  logic [DATA_W-1:0] eng_rdata,
  output logic              busy,
  output logic              err,
  output logic              abort_flag,
  output logic [IDX_W-1:0]  xfer_cnt,
  output logic [IDX_W-1:0]  occupancy,
  output logic              xfer_done,
  output logic              halt_done
);
  logic              dec_go, dec_rd, dec_chain, dec_rpt, dec_halt;
  logic [IDX_W-1:0]  dec_total;
  logic              seq_we;
  logic [PTR_W-1:0]  seq_idx;
  logic [DATA_W-1:0] seq_wdata;
  logic [DATA_W-1:0] seq_rdata;
  logic              unused_addr_lsb;

  assign unused_addr_lsb = addr_lo[0];

  i2cseq_ctrl_decode #(.IDX_W(IDX_W)) u_dec (
    .ctrl_byte (ctrl_byte),
    .go        (dec_go),
    .rd        (dec_rd),
    .chain     (dec_chain),
    .rpt_start (dec_rpt),
    .halt      (dec_halt),
    .total     (dec_total)
  );

  i2cseq_buffer #(.DATA_W(DATA_W), .DEPTH(DEPTH), .PTR_W(PTR_W)) u_buf (
    .clk          (clk),
    .rst_n        (rst_n),
    .host_we      (buf_wr),
    .host_idx     (buf_wr_idx),
    .host_data    (buf_wr_data),
    .seq_we       (seq_we),
    .seq_idx      (seq_idx),
    .seq_data     (seq_wdata),
    .host_rd_idx  (buf_rd_idx),
    .host_rd_data (buf_rd_data),
    .seq_rd_idx   (seq_idx),
    .seq_rd_data  (seq_rdata)
  );

  i2cseq_fsm #(.DATA_W(DATA_W), .PTR_W(PTR_W), .IDX_W(IDX_W), .ADDR_W(ADDR_W)) u_fsm (
    .clk        (clk),
    .rst_n      (rst_n),
    .cmd_wr     (ctrl_wr),
    .cmd_go     (dec_go),
    .cmd_rd     (dec_rd),
    .cmd_chain  (dec_chain),
    .cmd_rpt    (dec_rpt),
    .cmd_halt   (dec_halt),
    .cmd_total  (dec_total),
    .target     (addr_lo[ADDR_W:1]),
    .bus_busy   (bus_busy),
    .eng_done   (eng_done),
    .eng_nack   (eng_nack),
    .eng_rdata  (eng_rdata),
    .buf_rdata  (seq_rdata),
    .eng_req    (eng_req),
    .eng_op     (eng_op),
    .eng_addr   (eng_addr),
    .eng_rd     (eng_rd),
    .eng_wdata  (eng_wdata),
    .buf_we     (seq_we),
    .buf_idx    (seq_idx),
    .buf_wdata  (seq_wdata),
    .busy       (busy),
    .err        (err),
    .abort_flag (abort_flag),
    .xfer_cnt   (xfer_cnt),
    .occupancy  (occupancy),
    .xfer_done  (xfer_done),
    .halt_done  (halt_done)
  );
endmodule

// File: rtl/i2cseq_checker.sv
`timescale 1ns/1ps
module i2cseq_checker
  import i2cseq_pkg::*;
#(
  parameter int DEPTH = 4,
  parameter int IDX_W = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic             busy,
  input logic             err,
  input logic             abort_flag,
  input logic [IDX_W-1:0] xfer_cnt,
  input logic             xfer_done,
  input logic             halt_done,
  input logic             eng_req,
  input logic [1:0]       eng_op,
  input logic             eng_done,
  input logic             eng_nack
);
  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    eng_req && !eng_done |=> eng_req && $stable(eng_op)); // R12

  AST_NO_REQ_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !eng_req); // R11

  AST_CNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_cnt <= IDX_W'(DEPTH)); // R8

  AST_DONE_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_done |=> !busy && (xfer_cnt != '0)); // R8

  AST_NACK_ERR: assert property (@(posedge clk) disable iff (!rst_n)
    eng_req && eng_done && eng_nack && (eng_op == ENG_START || eng_op == ENG_SEND)
    |=> err && abort_flag); // R4

  AST_START_CLEARS_ERR: assert property (@(posedge clk) disable iff (!rst_n)
    eng_req && eng_done && !eng_nack && eng_op == ENG_START |=> !err); // R9

  AST_HALT_IS_STOP: assert property (@(posedge clk) disable iff (!rst_n)
    halt_done |-> eng_req && eng_op == ENG_STOP); // R10

  AST_ABORT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    abort_flag |=> abort_flag); // R9
endmodule

bind i2cseq_top i2cseq_checker #(.DEPTH(DEPTH), .IDX_W(IDX_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .busy       (busy),
  .err        (err),
  .abort_flag (abort_flag),
  .xfer_cnt   (xfer_cnt),
  .xfer_done  (xfer_done),
  .halt_done  (halt_done),
  .eng_req    (eng_req),
  .eng_op     (eng_op),
  .eng_done   (eng_done),
  .eng_nack   (eng_nack)
);

// File: tb/sim_i2cseq_top.sv
`timescale 1ns/1ps
module sim_i2cseq_top;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       ctrl_wr;
  logic [7:0] ctrl_byte;
  logic [7:0] addr_lo;
  logic       buf_wr;
  logic [1:0] buf_wr_idx;
  logic [7:0] buf_wr_data;
  logic [1:0] buf_rd_idx;
  logic [7:0] buf_rd_data;
  logic       bus_busy;
  logic       eng_req;
  logic [1:0] eng_op;
  logic [6:0] eng_addr;
  logic       eng_rd;
  logic [7:0] eng_wdata;
  logic       eng_done;
  logic       eng_nack;
  logic [7:0] eng_rdata;
  logic       busy, err, abort_flag, xfer_done, halt_done;
  logic [2:0] xfer_cnt, occupancy;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;

  // engine model state
  int nack_start_k = 99;
  int nack_send_k  = 99;
  int start_ctr, send_ctr, recv_ctr, stop_ctr;
  logic [6:0] last_addr;
  logic       last_rd;
  logic [7:0] sent_log [8];
  int done_ev = 0;
  int halt_ev = 0;

  // bench reference state
  bit m_err   = 0;
  bit m_abort = 0;
  logic [7:0] hb [4];

  always #2.5 clk = ~clk;

  i2cseq_top u0 (
    .clk(clk), .rst_n(rst_n), .ctrl_wr(ctrl_wr), .ctrl_byte(ctrl_byte),
    .addr_lo(addr_lo), .buf_wr(buf_wr), .buf_wr_idx(buf_wr_idx),
    .buf_wr_data(buf_wr_data), .buf_rd_idx(buf_rd_idx), .buf_rd_data(buf_rd_data),
    .bus_busy(bus_busy), .eng_req(eng_req), .eng_op(eng_op), .eng_addr(eng_addr),
    .eng_rd(eng_rd), .eng_wdata(eng_wdata), .eng_done(eng_done), .eng_nack(eng_nack),
    .eng_rdata(eng_rdata), .busy(busy), .err(err), .abort_flag(abort_flag),
    .xfer_cnt(xfer_cnt), .occupancy(occupancy), .xfer_done(xfer_done),
    .halt_done(halt_done)
  );

  function automatic logic [7:0] rpat(input int i);
    return 8'h3C ^ 8'(i * 8'h51);
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // event monitor away from the rising edge
  always @(negedge clk) begin
    if (rst_n) begin
      if (xfer_done) done_ev++;
      if (halt_done) halt_ev++;
    end
  end

  // watchdog
  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 150000) begin
        fails++;
        $display("FAIL R11 watchdog expired actual=%0d expected=<150000", cycles);
        $display("Simulation finished: %0d checks, %0d errors", checks, fails);
        $finish;
      end
    end
  end

  // bit-level engine model: acts 1 ns after each rising edge
  initial begin
    eng_done = 1'b0; eng_nack = 1'b0; eng_rdata = '0; bus_busy = 1'b0;
    forever begin
      @(posedge clk); #1;
      if (rst_n && eng_req) begin
        logic [1:0] op;
        logic       nk;
        logic       nb;
        int         lat;
        op  = eng_op;
        nk  = 1'b0;
        nb  = bus_busy;
        lat = int'($urandom_range(0, 2));
        repeat (lat) begin @(posedge clk); #1; end
        case (op)
          2'd0: begin
            nk = (start_ctr == nack_start_k);
            last_addr = eng_addr; last_rd = eng_rd;
            start_ctr++;
            if (!nk) nb = 1'b1;
          end
          2'd1: begin
            nk = (send_ctr == nack_send_k);
            if (send_ctr < 8) sent_log[send_ctr] = eng_wdata;
            send_ctr++;
          end
          2'd2: begin
            eng_rdata = rpat(recv_ctr);
            recv_ctr++;
          end
          default: begin
            stop_ctr++;
            nb = 1'b0;
          end
        endcase
        eng_done = 1'b1; eng_nack = nk; bus_busy = nb;
        @(posedge clk); #1;
        eng_done = 1'b0; eng_nack = 1'b0;
      end
    end
  end

  task automatic load_buf(input int j, input logic [7:0] d);
    @(negedge clk);
    buf_wr = 1'b1; buf_wr_idx = 2'(j); buf_wr_data = d;
    @(negedge clk);
    buf_wr = 1'b0;
    hb[j] = d;
  endtask

  task automatic wait_idle();
    int g = 0;
    while (busy && g < 2000) begin @(negedge clk); g++; end
    repeat (2) @(negedge clk);
  endtask

  task automatic run_cmd(input logic [7:0] ctrl, input int nks, input int nkd, input bit inject);
    int n;
    bit rd, ch, rp, b, stopped;
    int k, starts, stops, sends, dev0;
    logic [7:0] eb [4];
    n = int'(ctrl[5:4]) + 1;
    rd = ctrl[1]; ch = ctrl[2]; rp = ctrl[3];
    b = bus_busy; stopped = 0; k = 0; starts = 0; stops = 0; sends = 0;
    for (int i = 0; i < 4; i++) eb[i] = 8'h00;
    for (int i = 0; i < n; i++) begin
      if (!stopped && !b) begin
        if (starts == nks) begin m_err = 1; m_abort = 1; stopped = 1; end
        else begin m_err = 0; b = 1; end
        starts++;
      end
      if (!stopped) begin
        if (!rd) begin
          if (sends == nkd) begin m_err = 1; m_abort = 1; stopped = 1; end
          sends++;
        end else begin
          eb[i] = rpat(i);
        end
      end
      if (!stopped) begin
        k++;
        if (rp || !ch) begin stops++; b = 0; end
      end
    end
    nack_start_k = nks; nack_send_k = nkd;
    start_ctr = 0; send_ctr = 0; recv_ctr = 0; stop_ctr = 0;
    dev0 = done_ev;
    @(negedge clk);
    ctrl_byte = ctrl; ctrl_wr = 1'b1;
    @(negedge clk);
    ctrl_wr = 1'b0;
    chk("R11 busy after strobe", int'(busy), 1);
    if (inject) begin
      @(negedge clk);
      ctrl_byte = 8'h33; ctrl_wr = 1'b1;
      @(negedge clk);
      ctrl_wr = 1'b0;
    end
    wait_idle();
    chk("R8 xfer_cnt", int'(xfer_cnt), k);
    chk("R8 occupancy", int'(occupancy), k);
    chk("R8 done event", done_ev - dev0, (k > 0) ? 1 : 0);
    chk("R4/R9 err", int'(err), int'(m_err));
    chk("R4 abort_flag", int'(abort_flag), int'(m_abort));
    chk("R3 starts", start_ctr, starts);
    chk("R7 stops", stop_ctr, stops);
    chk("R7 bus held", int'(bus_busy), int'(b));
    if (starts > 0) begin
      chk("R2 address", int'(last_addr), int'(addr_lo[7:1]));
      chk("R2 direction", int'(last_rd), int'(rd));
    end
    if (!rd) begin
      for (int i = 0; i < k; i++) chk("R5 sent byte", int'(sent_log[i]), int'(hb[i]));
    end else begin
      for (int i = 0; i < k; i++) begin
        buf_rd_idx = 2'(i); #1;
        chk("R6 read byte", int'(buf_rd_data), int'(eb[i]));
        hb[i] = eb[i];
      end
    end
    if (inject) begin
      repeat (3) @(negedge clk);
      chk("R11 ignored write left idle", int'(busy), 0);
    end
  endtask

  task automatic run_halt(input logic [7:0] ctrl);
    int h0, d0;
    h0 = halt_ev; d0 = done_ev;
    start_ctr = 0; stop_ctr = 0;
    @(negedge clk);
    ctrl_byte = ctrl; ctrl_wr = 1'b1;
    @(negedge clk);
    ctrl_wr = 1'b0;
    wait_idle();
    chk("R10 halt event", halt_ev - h0, 1);
    chk("R10 one stop", stop_ctr, 1);
    chk("R10 no start", start_ctr, 0);
    chk("R10 no transfer event", done_ev - d0, 0);
    chk("R10 bus released", int'(bus_busy), 0);
  endtask

  initial begin
    rst_n = 1'b0; ctrl_wr = 1'b0; ctrl_byte = '0; addr_lo = 8'hA0;
    buf_wr = 1'b0; buf_wr_idx = '0; buf_wr_data = '0; buf_rd_idx = '0;
    for (int i = 0; i < 4; i++) hb[i] = 8'h00;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R11 reset busy", int'(busy), 0);
    chk("R11 reset err", int'(err), 0);
    chk("R11 reset abort", int'(abort_flag), 0);
    chk("R11 reset cnt", int'(xfer_cnt), 0);
    chk("R11 reset occupancy", int'(occupancy), 0);
    chk("R12 reset no request", int'(eng_req), 0);

    void'($urandom(32'h1D2C));
    load_buf(0, 8'h11); load_buf(1, 8'h22); load_buf(2, 8'h33); load_buf(3, 8'h44);

    // R7: four writes, no chain: start and stop around each byte
    addr_lo = 8'hA4;
    run_cmd(8'b0011_0001, 99, 99, 0);
    // R3/R7: four chained writes, one start, bus left held
    run_cmd(8'b0011_0101, 99, 99, 0);
    // R10: halt with go also set
    run_halt(8'b1000_0001);
    // R1: go clear and halt on idle bus does nothing
    begin
      int d0;
      d0 = done_ev;
      @(negedge clk); ctrl_byte = 8'b1011_0110; ctrl_wr = 1'b1;
      @(negedge clk); ctrl_wr = 1'b0;
      repeat (3) @(negedge clk);
      chk("R1 no go stays idle", int'(busy), 0);
      chk("R1 no go no event", done_ev - d0, 0);
    end
    // R6/R7: three reads with chain and repeated start
    addr_lo = 8'h3F;
    run_cmd(8'b0010_1111, 99, 99, 0);
    // R4: nack on first address
    run_cmd(8'b0001_0001, 0, 99, 0);
    // R9: clean write clears err, abort stays
    run_cmd(8'b0000_0001, 99, 99, 0);
    // R5: data nack on second byte, chained, bus stays held
    run_cmd(8'b0011_0101, 99, 1, 0);
    // R3: read on held bus: no start first, start before the second byte
    run_cmd(8'b0001_0011, 99, 99, 0);
    // R4: nack on second start after one byte
    run_cmd(8'b0010_0001, 1, 99, 0);
    // R2: ten-bit request runs with the 7-bit address
    addr_lo = 8'hE7;
    run_cmd(8'b0101_0011, 99, 99, 0);
    // R11: control byte while busy is ignored
    run_cmd(8'b0011_0001, 99, 99, 1);

    // random commands
    for (int t = 0; t < 80; t++) begin
      logic [7:0] c;
      int nks, nkd;
      if (bus_busy && ($urandom_range(0, 2) == 0)) begin
        run_halt(8'h80 | 8'($urandom_range(0, 1)));
      end else begin
        addr_lo = 8'($urandom);
        if ($urandom_range(0, 1) == 0) load_buf(int'($urandom_range(0, 3)), 8'($urandom));
        c = 8'($urandom) & 8'h7E;
        c[0] = 1'b1;
        nks = ($urandom_range(0, 3) == 0) ? int'($urandom_range(0, 3)) : 99;
        nkd = ($urandom_range(0, 3) == 0) ? int'($urandom_range(0, 3)) : 99;
        run_cmd(c, nks, nkd, ($urandom_range(0, 7) == 0));
      end
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, fails);
    $finish;
  end
endmodule